// File: doc/BRIEF.md
# Dithered First-Order Delta-Sigma Modulator

This block is a clocked digital model of a first-order delta-sigma loop. Each clock it takes an unsigned sample and updates an integrator with the sample minus a fed-back level, plus an optional dither term. A mid-scale comparator turns the integrator level into one output bit, and that bit returns through a 1-bit DAC as either zero or full scale. Over many clocks, the density of ones in the bit stream follows the input level divided by full scale. A downstream decimation filter, which is not part of this block, recovers the value.

The integrator keeps its state with a fixed positive bias of twice the full-scale range, so the arithmetic is unsigned and cannot wrap during a loop update. The observed level is the state minus the bias, clamped to the 8-bit range. A slow mode keeps four extra fraction bits and adds the difference without scaling, so integration is sixteen times slower. The dither source is a pseudo-random shift register. It adds a small signed value that breaks up the periodic patterns a constant input would otherwise produce.

Top module: `dsm_dither_top`

## Requirements
- R1: A synchronous active-high reset sets the observed level integOut to 128, clears bitOut to 0 and loads the dither register with 16'hACE1. Both outputs hold these values while reset is asserted.
- R2: Each clock outside reset, in normal mode, the signed integrator level L becomes L + sampleIn - F + d. F is the DAC value of the current bitOut (0 for a 0 bit, 255 for a 1 bit) and d is the dither value. The state is held as L + 512, so a loop update never wraps.
- R3: integOut shows L clamped to the range 0 to 255. A level above 255 reads as 255 and a level below 0 reads as 0, while the hidden state keeps the true value.
- R4: After each update, bitOut is 1 exactly when the new level L is 128 or more. So after the first update, bitOut equals (integOut >= 128).
- R5: With slowMode high, the level is tracked in units of 1/16: the unscaled difference is added to a state that has four fraction bits, and integOut shows the floor of L. The observed level then moves by at most 17 per clock.
- R6: With a constant input and dither off, the number of ones in 1024 clocks after reset is within 3 of round(sampleIn*1024/255) in normal mode, and within 4 in slow mode.
- R7: The dither register is a 16-bit Fibonacci LFSR that shifts left every clock after reset. The new bit 0 is the XOR of bits 15, 13, 12 and 10. When ditherEn is high, d is bits [2:0] of the register read as a signed 3-bit value (-4..3), taken before the register shifts at that same edge. When ditherEn is low, d is 0. With dither on, the ones count over 1024 clocks is within 6 of round(sampleIn*1024/255).
- R8: With input 85 and dither off, the output stream repeats with period 3. With dither on, that period-3 pattern is broken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | 8 | Unsigned input sample |
| slowMode | input | 1 | 1 selects the 16x slower integration |
| ditherEn | input | 1 | 1 adds the pseudo-random dither term |
| bitOut | output | 1 | Modulated 1-bit stream |
| integOut | output | 8 | Observed integrator level, clamped to 0..255 |

## Verification
The bench builds the block with its defaults: 8-bit samples, four fraction bits for slow mode and a 16-bit dither register. These values make full scale 255, so counting ones over 1024 clocks resolves each input to within a few counts. The slow-mode step limit of 17 per clock and the exact dither sequence from the fixed seed can both be predicted by hand. A cycle-exact model written from the requirements covers normal, slow and dithered runs. Hand-derived sequences cover the clamp, the threshold at 127 and 128, and the first two dither values.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  // Width of the signed dither slice taken from the LFSR
  localparam int DITHER_W = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic                       slowStep;
    logic                       ditherOn;
    logic signed [DITHER_W-1:0] ditherVal;
  } dsm_ctrl_t;
endpackage

// File: rtl/dsm_ctrl.sv
module dsm_ctrl
  import dsm_pkg::*;
#(
  parameter int              LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      slowMode,
  input  logic      ditherEn,
  output dsm_ctrl_t ctrlOut
);
  logic [LFSR_W-1:0] lfsrQ;
  logic              feedBit;

  // Fibonacci feedback: parity of the tapped bits
  assign feedBit = ^(lfsrQ & LFSR_TAPS);

  always_ff @(posedge clk) begin
    if (rst) lfsrQ <= LFSR_SEED;
    else     lfsrQ <= {lfsrQ[LFSR_W-2:0], feedBit};
  end

  always_comb begin
    ctrlOut.slowStep  = slowMode;
    ctrlOut.ditherOn  = ditherEn;
    ctrlOut.ditherVal = ditherEn ? $signed(lfsrQ[DITHER_W-1:0]) : '0;
  end
endmodule

// File: rtl/dsm_datapath.sv
module dsm_datapath
  import dsm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sampleIn,
  input  dsm_ctrl_t         ctrlIn,
  output logic              bitOut,
  output logic [DATA_W-1:0] integOut
);
  localparam int INT_W  = DATA_W + 2;
  localparam int ACC_W  = INT_W + FRAC_W;
  localparam int SUM_W  = ACC_W + 2;
  localparam int DIFF_W = DATA_W + 2;
  localparam logic [INT_W-1:0] BIAS    = INT_W'(2 ** (DATA_W + 1));
  localparam logic [INT_W-1:0] FULL_I  = INT_W'(2 ** DATA_W - 1);
  localparam logic [INT_W-1:0] THR_I   = INT_W'(2 ** (DATA_W - 1));
  localparam logic [INT_W-1:0] TOP_I   = BIAS + FULL_I;
  localparam logic [INT_W-1:0] CMP_I   = BIAS + THR_I;
  localparam logic [ACC_W-1:0] ACC_RST = {CMP_I, {FRAC_W{1'b0}}};
  localparam logic [DATA_W-1:0] FULL   = {DATA_W{1'b1}};

  logic [ACC_W-1:0]        accQ, accNext;
  logic                    bitQ, bitNext;
  logic [DATA_W-1:0]       dacLevel;
  logic signed [DIFF_W-1:0] diffVal, ditherExt;
  logic signed [SUM_W-1:0] stepVal, sumVal;

  // Biased integer part to observed level, clamped to the output range
  function automatic logic [DATA_W-1:0] levelOf(input logic [ACC_W-1:0] acc);
    logic [INT_W-1:0] intPart;
    logic [INT_W-1:0] offs;
    intPart = acc[ACC_W-1:FRAC_W];
    offs    = intPart - BIAS;
    if (intPart < BIAS)       return '0;
    else if (intPart > TOP_I) return FULL;
    else                      return offs[DATA_W-1:0];
  endfunction

  // 1-bit feedback DAC
  assign dacLevel  = bitQ ? FULL : '0;
  assign ditherExt = DIFF_W'(ctrlIn.ditherVal);
  assign diffVal   = $signed({2'b00, sampleIn}) - $signed({2'b00, dacLevel}) + ditherExt;

  // Normal mode scales the difference up to the integer position
  assign stepVal = ctrlIn.slowStep ? SUM_W'(diffVal) : (SUM_W'(diffVal) <<< FRAC_W);
  assign sumVal  = $signed({2'b00, accQ}) + stepVal;

  always_comb begin
    if (sumVal[SUM_W-1])               accNext = '0;
    else if (|sumVal[SUM_W-2:ACC_W])   accNext = '1;
    else                               accNext = sumVal[ACC_W-1:0];
  end

  // Mid-scale comparator on the updated level
  assign bitNext = (accNext[ACC_W-1:FRAC_W] >= CMP_I);

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ <= ACC_RST;
      bitQ <= 1'b0;
    end else begin
      accQ <= accNext;
      bitQ <= bitNext;
    end
  end

  assign bitOut   = bitQ;
  assign integOut = levelOf(accQ);
endmodule

// File: rtl/dsm_dither_top.sv
module dsm_dither_top
  import dsm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 4,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              slowMode,
  input  logic              ditherEn,
  output logic              bitOut,
  output logic [DATA_W-1:0] integOut
);
  dsm_ctrl_t ctrlBus;

  dsm_ctrl #(
    .LFSR_W(LFSR_W), .LFSR_TAPS(LFSR_TAPS), .LFSR_SEED(LFSR_SEED)
  ) ctrl_i (
    .clk(clk), .rst(rst), .slowMode(slowMode), .ditherEn(ditherEn), .ctrlOut(ctrlBus)
  );

  dsm_datapath #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W)
  ) path_i (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .ctrlIn(ctrlBus),
    .bitOut(bitOut), .integOut(integOut)
  );
endmodule

// File: rtl/dsm_dither_checker.sv
module dsm_dither_checker
  import dsm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              slowMode,
  input logic              ditherEn,
  input logic              bitOut,
  input logic [DATA_W-1:0] integOut
);
  localparam int SLOW_MAX = ((2 ** DATA_W - 1) + 2 ** (DITHER_W - 1)) / (2 ** FRAC_W) + 1;
  localparam logic [DATA_W-1:0] THR = DATA_W'(2 ** (DATA_W - 1));
  localparam logic [DATA_W-1:0] MID = THR;

  logic              prevRstQ, prevSlow, prevDither, prevBit;
  logic [DATA_W-1:0] prevOut, stepMag;

  always_ff @(posedge clk) begin
    prevRstQ   <= rst;
    prevSlow   <= slowMode;
    prevDither <= ditherEn;
    prevBit    <= bitOut;
    prevOut    <= integOut;
  end

  assign stepMag = (integOut >= prevOut) ? (integOut - prevOut) : (prevOut - integOut);

  always_ff @(posedge clk) begin
    if (prevRstQ) begin
      assert_reset_state_R1: assert (integOut == MID && !bitOut);
    end
  end

  assert_bit_matches_level_R4: assert property (@(posedge clk) disable iff (rst)
    !prevRstQ |-> (bitOut == (integOut >= THR)));

  assert_one_never_raises_R2: assert property (@(posedge clk) disable iff (rst)
    (!prevRstQ && prevBit && !prevDither) |-> (integOut <= prevOut));

  assert_zero_never_lowers_R2: assert property (@(posedge clk) disable iff (rst)
    (!prevRstQ && !prevBit && !prevDither) |-> (integOut >= prevOut));

  assert_slow_step_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (!prevRstQ && prevSlow) |-> (int'(stepMag) <= SLOW_MAX));
endmodule

bind dsm_dither_top dsm_dither_checker #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) chk_i (
  .clk(clk), .rst(rst), .slowMode(slowMode), .ditherEn(ditherEn),
  .bitOut(bitOut), .integOut(integOut)
);

// File: tb/dsm_dither_top_tb_top.sv
module dsm_dither_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sampleIn = 8'd0;
  logic       slowMode = 1'b0;
  logic       ditherEn = 1'b0;
  logic       bitOut;
  logic [7:0] integOut;

  int totalChecks = 0;
  int failChecks  = 0;
  bit finished    = 0;

  // Reference state written from the requirements
  int          mAcc;
  bit          mBit;
  logic [15:0] mLfsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsm_dither_top dut_i (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .slowMode(slowMode),
    .ditherEn(ditherEn), .bitOut(bitOut), .integOut(integOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    totalChecks++;
    if (!ok) begin
      failChecks++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampLevel(input int acc);
    int v;
    v = acc >>> 4;
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  task automatic modelReset();
    mAcc  = 128 * 16;
    mBit  = 0;
    mLfsr = 16'hACE1;
  endtask

  task automatic modelStep(input int inVal, input bit slow, input bit dith);
    int d, diff;
    d    = dith ? int'($signed(mLfsr[2:0])) : 0;
    diff = inVal - (mBit ? 255 : 0) + d;
    mAcc = slow ? (mAcc + diff) : (mAcc + diff * 16);
    mBit = ((mAcc >>> 4) >= 128);
    mLfsr = {mLfsr[14:0], mLfsr[15] ^ mLfsr[13] ^ mLfsr[12] ^ mLfsr[10]};
  endtask

  // One clock: inputs already set, outputs sampled at the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    tick();
    tick();
    check(integOut == 8'd128, "R1 reset level", integOut, 128);
    check(bitOut == 1'b0, "R1 reset bit", bitOut, 0);
    rst = 1'b0;
    modelReset();
  endtask

  task automatic stepExpect(input int inVal, input int expLvl, input int expBit, input string tag);
    sampleIn = 8'(inVal);
    tick();
    check(integOut == 8'(expLvl), {tag, " level"}, integOut, expLvl);
    check(bitOut == expBit[0], {tag, " bit"}, bitOut, expBit);
  endtask

  task automatic testClampR3();
    slowMode = 0; ditherEn = 0;
    doReset();
    stepExpect(200, 255, 1, "R3 clamp high step1");
    stepExpect(200, 255, 1, "R3 clamp high step2");
    stepExpect(200, 218, 1, "R3 hidden state kept");
    stepExpect(0, 0, 0, "R3 clamp low");
  endtask

  task automatic testThresholdR4();
    slowMode = 0; ditherEn = 0;
    doReset();
    stepExpect(0, 128, 1, "R4 level 128");
    stepExpect(0, 0, 0, "R4 negative level");
    stepExpect(254, 127, 0, "R4 level 127");
    stepExpect(1, 128, 1, "R4 level 128 again");
  endtask

  task automatic testSlowR5();
    slowMode = 1; ditherEn = 0;
    doReset();
    stepExpect(255, 143, 1, "R5 slow rise");
    stepExpect(255, 143, 1, "R5 slow hold");
    stepExpect(0, 128, 1, "R5 slow fall");
    stepExpect(0, 112, 0, "R5 slow fall2");
    slowMode = 0;
  endtask

  task automatic testDitherSeedR7();
    slowMode = 0; ditherEn = 1;
    doReset();
    stepExpect(0, 129, 1, "R7 first dither +1");
    stepExpect(0, 0, 0, "R7 second dither +3");
    ditherEn = 0;
  endtask

  task automatic runModel(input int cycles, input bit slow, input bit dith, input string tag);
    int errs = 0;
    slowMode = slow; ditherEn = dith;
    doReset();
    for (int i = 0; i < cycles; i++) begin
      int inVal;
      inVal = (i * 37 + 11) % 256;
      sampleIn = 8'(inVal);
      tick();
      modelStep(inVal, slow, dith);
      if (integOut != 8'(clampLevel(mAcc)) || bitOut != mBit) begin
        errs++;
        $display("FAIL %s cycle %0d actual=%0d/%0d expected=%0d/%0d",
                 tag, i, integOut, bitOut, clampLevel(mAcc), mBit);
      end
    end
    totalChecks++;
    if (errs != 0) failChecks++;
    slowMode = 0; ditherEn = 0;
  endtask

  task automatic density(input int inVal, input bit slow, input bit dith, input int tol, input string tag);
    int ones = 0;
    int expOnes, dev;
    slowMode = slow; ditherEn = dith;
    doReset();
    sampleIn = 8'(inVal);
    for (int i = 0; i < 1024; i++) begin
      tick();
      if (bitOut) ones++;
    end
    expOnes = (inVal * 1024 + 127) / 255;
    dev = ones - expOnes;
    if (dev < 0) dev = -dev;
    check(dev <= tol, tag, ones, expOnes);
    slowMode = 0; ditherEn = 0;
  endtask

  task automatic patternR8(input bit dith, output int breaks);
    bit hist[$];
    breaks = 0;
    ditherEn = dith; slowMode = 0;
    doReset();
    sampleIn = 8'd85;
    for (int i = 0; i < 300; i++) begin
      tick();
      hist.push_back(bitOut);
    end
    for (int i = 10; i < 300; i++) if (hist[i] != hist[i-3]) breaks++;
    ditherEn = 0;
  endtask

  task automatic testPatternR8();
    int b0, b1;
    patternR8(0, b0);
    check(b0 == 0, "R8 period-3 without dither", b0, 0);
    patternR8(1, b1);
    check(b1 > 0, "R8 pattern broken with dither", b1, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      totalChecks++;
      failChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
      $finish;
    end
  end

  initial begin
    testClampR3();
    testThresholdR4();
    testSlowR5();
    testDitherSeedR7();
    runModel(96, 0, 0, "R2 normal model");
    runModel(96, 1, 0, "R5 slow model");
    runModel(200, 0, 1, "R7 dithered model");
    runModel(200, 1, 1, "R7 dithered slow model");
    density(3,   0, 0, 3, "R6 density in=3");
    density(64,  0, 0, 3, "R6 density in=64");
    density(128, 0, 0, 3, "R6 density in=128");
    density(200, 0, 0, 3, "R6 density in=200");
    density(252, 0, 0, 3, "R6 density in=252");
    density(100, 1, 0, 4, "R6 slow density in=100");
    density(50,  0, 1, 6, "R7 dithered density in=50");
    density(180, 0, 1, 6, "R7 dithered density in=180");
    testPatternR8();
    finished = 1;
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end
endmodule